// File: doc/BRIEF.md
# Signal Voltage Switch Sequencer

This block owns the enable bit that selects the I/O signaling voltage of an SD/eMMC host. Software writes the bit; a write that changes the bit starts a switch of the I/O-cell regulator between 3.3 V and 1.8 V. Only the I/O cell voltage moves; the card supply stays at 3.3 V and is not touched here.

After a switch starts, the block waits for the regulator's power-good report to reach the new level. The wait is bounded by a settle window, counted in clock cycles and derived from the clock frequency and a microsecond budget (5 ms by default). A busy flag covers the whole switch, and writes that arrive during a switch are dropped. When the regulator has not reached 1.8 V by the end of the window, the block clears the enable bit by itself and returns the regulator to 3.3 V. A request for 1.8 V is accepted only when at least one of the UHS capability inputs (SDR50, SDR104, DDR50) is high.

Top module: `sigv_switch_seq`

## Requirements
- R1: After a synchronous reset, `sig18_en`, `vio_sel_low`, `busy` and `sw_fail` are all 0 (0 on `sig18_en` means 3.3 V signaling, 1 means 1.8 V).
- R2: When idle with `sig18_en`=0, a write of 1 (`ctl_wr`=1, `ctl_wdata`=1) while any capability input is 1 makes `sig18_en`, `vio_sel_low` and `busy` all 1 one cycle later, and `sw_fail` 0.
- R3: A write of 1 while all three capability inputs are 0 is ignored: `sig18_en`, `vio_sel_low` and `busy` stay 0.
- R4: When idle with `sig18_en`=1, a write of 0 makes `sig18_en` and `vio_sel_low` 0 and `busy` 1 one cycle later.
- R5: Writes while `busy` is 1 are ignored and do not change `sig18_en`.
- R6: A write of the value `sig18_en` already holds is ignored and does not raise `busy`.
- R7: `vio_low_ok` (1 = regulator settled at 1.8 V, 0 = settled at 3.3 V) passes through a SYNC_STAGES-flop synchronizer; a switch ends as a success on the first cycle the synchronized value equals the target level, so if the input reaches the target D cycles after the start, `busy` stays high for D+SYNC_STAGES+1 cycles.
- R8: `busy` never stays high for more than SETTLE_CYCLES = CLK_HZ/1e6 * SETTLE_US cycles; when the window runs out without a match, `busy` falls after exactly SETTLE_CYCLES cycles.
- R9: A switch to 1.8 V that runs out of window clears `sig18_en` and `vio_sel_low` to 0 and sets `sw_fail`.
- R10: A switch to 3.3 V that runs out of window sets `sw_fail` and leaves `sig18_en` at 0.
- R11: `sw_fail` stays set until the next accepted write, which clears it; a successful switch leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the enable bit |
| ctl_wdata | input | 1 | Value written to the enable bit |
| cap_sdr50 | input | 1 | Host advertises SDR50 |
| cap_sdr104 | input | 1 | Host advertises SDR104 |
| cap_ddr50 | input | 1 | Host advertises DDR50 |
| vio_low_ok | input | 1 | Regulator report: 1 = settled at 1.8 V, 0 = settled at 3.3 V |
| vio_sel_low | output | 1 | Regulator select: 1 = 1.8 V, 0 = 3.3 V |
| sig18_en | output | 1 | Enable bit readback |
| busy | output | 1 | A switch is in progress |
| sw_fail | output | 1 | Last switch ran out of window |

## Verification
The bench builds the block with CLK_HZ = 2 MHz and SETTLE_US = 4, giving an 8-cycle window, and keeps two synchronizer stages. With so short a window it sweeps the regulator response delay in both directions from zero up to past the window edge, so the exact boundary where a success turns into a timeout, and the self-clear that follows, is hit every run. All eight capability combinations are also tried against a write of 1.

// File: rtl/sigv_pkg.sv
package sigv_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RISE = 2'd1,
    SW_FALL = 2'd2
  } sw_state_t;

  localparam int CAP_W = 3;
endpackage

// File: rtl/sigv_req_gate.sv
module sigv_req_gate #(
  parameter int CAP_W = 3
) (
  input  logic             wr,
  input  logic             wdata,
  input  logic [CAP_W-1:0] caps,
  input  logic             cur_en,
  input  logic             idle,
  output logic             go_low,
  output logic             go_high
);
  // A write only counts when idle and when it changes the bit.
  always_comb begin
    go_low  = idle && wr && wdata && !cur_en && (|caps);
    go_high = idle && wr && !wdata && cur_en;
  end
endmodule

// File: rtl/sigv_sync.sv
module sigv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/sigv_settle_timer.sv
module sigv_settle_timer #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (start) cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

  // R8: the window counter never passes its terminal count
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= LAST));
endmodule

// File: rtl/sigv_switch_seq.sv
module sigv_switch_seq #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SETTLE_US   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic ctl_wdata,
  input  logic cap_sdr50,
  input  logic cap_sdr104,
  input  logic cap_ddr50,
  input  logic vio_low_ok,
  output logic vio_sel_low,
  output logic sig18_en,
  output logic busy,
  output logic sw_fail
);
  import sigv_pkg::*;

  localparam int SETTLE_CYCLES = (CLK_HZ / 1_000_000) * SETTLE_US;

  sw_state_t          state;
  logic [CAP_W-1:0]   caps;
  logic               go_low, go_high, pg_q, expire, idle;

  assign caps = {cap_ddr50, cap_sdr104, cap_sdr50};
  assign idle = (state == SW_IDLE);

  sigv_req_gate #(.CAP_W(CAP_W)) gate_i (
    .wr(ctl_wr), .wdata(ctl_wdata), .caps(caps), .cur_en(sig18_en),
    .idle(idle), .go_low(go_low), .go_high(go_high)
  );

  sigv_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(vio_low_ok), .q(pg_q)
  );

  sigv_settle_timer #(.LIMIT(SETTLE_CYCLES)) timer_i (
    .clk(clk), .rst(rst), .start(go_low || go_high), .run(!idle),
    .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SW_IDLE;
      sig18_en    <= 1'b0;
      vio_sel_low <= 1'b0;
      sw_fail     <= 1'b0;
    end else begin
      case (state)
        SW_IDLE: begin
          if (go_low) begin
            sig18_en    <= 1'b1;
            vio_sel_low <= 1'b1;
            sw_fail     <= 1'b0;
            state       <= SW_RISE;
          end else if (go_high) begin
            sig18_en    <= 1'b0;
            vio_sel_low <= 1'b0;
            sw_fail     <= 1'b0;
            state       <= SW_FALL;
          end
        end
        SW_RISE: begin
          if (pg_q) begin
            state <= SW_IDLE;
          end else if (expire) begin
            sig18_en    <= 1'b0;
            vio_sel_low <= 1'b0;
            sw_fail     <= 1'b1;
            state       <= SW_IDLE;
          end
        end
        SW_FALL: begin
          if (!pg_q) begin
            state <= SW_IDLE;
          end else if (expire) begin
            sw_fail <= 1'b1;
            state   <= SW_IDLE;
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  assign busy = !idle;

  // R2: an accepted request for 1.8 V starts a switch next cycle
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctl_wr && ctl_wdata && !sig18_en &&
     (cap_sdr50 || cap_sdr104 || cap_ddr50)) |=> (busy && sig18_en && vio_sel_low));

  // R3: no capability means the bit stays 0
  p_nocap_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctl_wr && ctl_wdata && !sig18_en &&
     !cap_sdr50 && !cap_sdr104 && !cap_ddr50) |=> (!sig18_en && !busy));

  // R5: a write during a switch only sees the bit move by a self-clear
  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_wr) |=> ((sig18_en == $past(sig18_en)) || (!sig18_en && sw_fail)));

  // R9: the bit only drops without a write when the switch failed
  p_selfclear_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(sig18_en) && $past(busy)) |-> (sw_fail && !vio_sel_low));

  // R6: rewriting the held value does not start a switch
  p_same_value_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctl_wr && (ctl_wdata == sig18_en)) |=> !busy);
endmodule

// File: tb/sigv_switch_seq_tb_top.sv
module sigv_switch_seq_tb_top;
  localparam int CLK_HZ = 2_000_000;
  localparam int SET_US = 4;
  localparam int SYNC   = 2;
  localparam int WIN    = (CLK_HZ / 1_000_000) * SET_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 1'b0, ctl_wdata = 1'b0;
  logic cap_sdr50 = 1'b0, cap_sdr104 = 1'b0, cap_ddr50 = 1'b0;
  logic vio_low_ok = 1'b0;
  logic vio_sel_low, sig18_en, busy, sw_fail;

  int n_total = 0;
  int n_bad   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  sigv_switch_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SET_US), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cap_sdr50(cap_sdr50), .cap_sdr104(cap_sdr104), .cap_ddr50(cap_ddr50),
    .vio_low_ok(vio_low_ok), .vio_sel_low(vio_sel_low), .sig18_en(sig18_en),
    .busy(busy), .sw_fail(sw_fail)
  );

  task automatic check(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one write cycle; returns at the negedge after the accepting edge.
  task automatic wr(input logic v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // Run a switch until busy drops; regulator reaches tgt at index dly (dly<0: never).
  task automatic run_switch(input int dly, input logic tgt, output int len);
    len = 0;
    for (int i = 0; i < 4 * WIN; i++) begin
      if (i == dly) vio_low_ok = tgt;
      if (!busy) break;
      len++;
      @(negedge clk);
    end
  endtask

  // Let the regulator input match the select and settle through the sync.
  task automatic settle_rail();
    vio_low_ok = vio_sel_low;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_total++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int len;
    int exp_len;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 en", sig18_en, 0);
    check("R1 sel", vio_sel_low, 0);
    check("R1 busy", busy, 0);
    check("R1 fail", sw_fail, 0);

    // R3 / R2: sweep every capability combination against a write of 1
    for (int c = 0; c < 8; c++) begin
      {cap_ddr50, cap_sdr104, cap_sdr50} = 3'(c);
      wr(1'b1);
      if (c == 0) begin
        check("R3 en", sig18_en, 0);
        check("R3 busy", busy, 0);
        check("R3 sel", vio_sel_low, 0);
      end else begin
        check("R2 en", sig18_en, 1);
        check("R2 sel", vio_sel_low, 1);
        check("R2 busy", busy, 1);
        check("R2 fail", sw_fail, 0);
        run_switch(0, 1'b1, len);
        check("R7 len", len, SYNC + 1);
        wr(1'b0);
        check("R4 en", sig18_en, 0);
        check("R4 sel", vio_sel_low, 0);
        check("R4 busy", busy, 1);
        run_switch(0, 1'b0, len);
        check("R7 down len", len, SYNC + 1);
      end
      settle_rail();
    end
    cap_sdr104 = 1'b1; cap_sdr50 = 1'b0; cap_ddr50 = 1'b0;

    // R6: writing 0 when already 0 does nothing
    wr(1'b0);
    check("R6 busy0", busy, 0);
    check("R6 en0", sig18_en, 0);

    // Delay sweep in both directions across the window edge
    for (int d = 0; d <= WIN; d++) begin
      exp_len = (d + SYNC + 1 <= WIN) ? d + SYNC + 1 : WIN;
      ok = (d + SYNC + 1 <= WIN);
      wr(1'b1);
      run_switch(d, 1'b1, len);
      check(ok ? "R7 up len" : "R8 up len", len, exp_len);
      check(ok ? "R11 up ok" : "R9 fail set", sw_fail, ok ? 0 : 1);
      check(ok ? "R7 en kept" : "R9 self clear", sig18_en, ok ? 1 : 0);
      check("R9 sel tracks", vio_sel_low, ok ? 1 : 0);
      settle_rail();
      if (!ok) begin
        // R11: next accepted write clears the failure flag
        vio_low_ok = 1'b0;
        wr(1'b1);
        check("R11 clear", sw_fail, 0);
        run_switch(0, 1'b1, len);
        settle_rail();
      end
      // R6: writing 1 when already 1 does nothing
      wr(1'b1);
      check("R6 busy1", busy, 0);
      wr(1'b0);
      run_switch(d, 1'b0, len);
      check(ok ? "R7 dn len" : "R8 dn len", len, exp_len);
      check(ok ? "R11 dn ok" : "R10 fail set", sw_fail, ok ? 0 : 1);
      check("R10 en low", sig18_en, 0);
      settle_rail();
    end

    // R5: writes during a switch are ignored
    wr(1'b1);
    wr(1'b0);
    check("R5 en held", sig18_en, 1);
    check("R5 busy", busy, 1);
    run_switch(0, 1'b1, len);
    check("R5 en after", sig18_en, 1);
    wr(1'b0);
    wr(1'b1);
    check("R5 en held low", sig18_en, 0);
    run_switch(0, 1'b0, len);
    check("R5 en after low", sig18_en, 0);
    check("R5 fail", sw_fail, 0);

    // R1: reset from an active 1.8 V state
    settle_rail();
    wr(1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 re en", sig18_en, 0);
    check("R1 re busy", busy, 0);
    check("R1 re sel", vio_sel_low, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule